// File: doc/BRIEF.md
# Ready/Valid Circular-Buffer Queue

This block is a first-in first-out queue placed between a producer stream and a consumer stream. Both sides use a ready/valid handshake. A word moves across a side only in a cycle where that side's valid and ready are both high. Accepted words are kept in a circular store of `DEPTH` slots. A write position steps forward on each accepted word and a read position steps forward on each delivered word, and both return to slot 0 after slot `DEPTH-1`. The queue also drives the number of words it holds as a plain binary output.

Two elaboration-time switches change the timing at the edges of the queue. With `READY_PASS` set, the producer-side ready also follows the consumer-side ready, so a full queue can take a new word in the same cycle that its oldest word leaves. With `VALID_BYPASS` set, an empty queue shows an incoming word on its output in the same cycle, and that word is never written into the store if the consumer takes it. With both switches clear, both handshake flags come only from the registered occupancy.

Top module: `rvq_fifo`

## Requirements
- R1: After synchronous reset, `fill` is 0, `in_ready` is 1 and `out_valid` is 0 (with `in_valid` low).
- R2: A transfer happens on a side only when its valid and ready are both high. `fill` rises by one when only the input side transfers, falls by one when only the output side transfers, and otherwise holds, including when both sides transfer.
- R3: `fill` never exceeds `DEPTH`. With `READY_PASS` clear, `in_ready` equals (`fill` < `DEPTH`), so a full queue refuses input and keeps its count.
- R4: With `VALID_BYPASS` clear, `out_valid` equals (`fill` > 0). The output side never transfers while `fill` is 0, except through the bypass path of R8.
- R5: Words leave in exactly the order they were accepted, and none is lost or duplicated.
- R6: The write and read slot positions wrap from `DEPTH-1` to 0, and the write position always equals (read position + `fill`) mod `DEPTH`. Order is therefore kept across any number of wraps.
- R7: With `READY_PASS` set, `in_ready` = (`fill` < `DEPTH`) OR `out_ready`. An accepted word while full leaves `fill` at `DEPTH`.
- R8: With `VALID_BYPASS` set and `fill` = 0, `out_valid` follows `in_valid` and `out_data` equals `in_data` in the same cycle. A word passed this way leaves `fill` at 0.
- R9: Whenever `fill` > 0, `out_data` is the oldest stored word and `out_valid` is 1, whatever the settings of the two switches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer offers a word |
| in_data | input | WIDTH | Offered word |
| in_ready | output | 1 | Queue can accept a word |
| out_valid | output | 1 | Queue offers a word |
| out_data | output | WIDTH | Offered word |
| out_ready | input | 1 | Consumer takes the word |
| fill | output | $clog2(DEPTH+1) | Number of words held, 0 to DEPTH |

## Verification
Four assertions run on every cycle. One keeps `fill` within its range. One ties each change of `fill` to the transfers of the previous cycle. One keeps the two slot positions consistent with `fill`. One forbids an output transfer from an empty queue unless a bypassed input transfer happens in the same cycle. Two more check the edge cases: a transfer while full keeps the queue full, and a bypass from empty keeps it empty. The assertions cannot show that the data arrives in order and unchanged, that the handshake flags take their correct combinational values under each switch setting, or that the store gives correct results over many wraps. Only the bench shows these, by comparing two configurations against a reference queue, both in random traffic and in directed runs to full, to empty and through the bypass.

// File: rtl/rvq_pkg.sv
package rvq_pkg;
   // Bits needed to address n slots; at least one bit.
   function automatic int slot_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // Bits needed to hold the values 0 to n inclusive.
   function automatic int fill_bits(input int n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/rvq_wrap_ptr.sv
module rvq_wrap_ptr #(
   parameter int DEPTH = 4,
   localparam int PW = rvq_pkg::slot_bits(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          step,
   output logic [PW-1:0] pos
);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   always_ff @(posedge clk) begin
      if (rst)
         pos <= '0;
      else if (step)
         pos <= (pos == LAST) ? '0 : pos + PW'(1);
   end

   // R6: the position never leaves the slot range
   assert_pos_range_R6: assert property (@(posedge clk) disable iff (rst)
      int'(pos) < DEPTH);
endmodule

// File: rtl/rvq_store.sv
module rvq_store #(
   parameter int DEPTH = 4,
   parameter int WIDTH = 8,
   localparam int PW = rvq_pkg::slot_bits(DEPTH)
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [PW-1:0]    wr_pos,
   input  logic [WIDTH-1:0] wr_word,
   input  logic [PW-1:0]    rd_pos,
   output logic [WIDTH-1:0] rd_word
);
   logic [WIDTH-1:0] slots [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en)
         slots[wr_pos] <= wr_word;
   end

   assign rd_word = slots[rd_pos];
endmodule

// File: rtl/rvq_occupancy.sv
module rvq_occupancy #(
   parameter int DEPTH = 4,
   localparam int CW = rvq_pkg::fill_bits(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          grow,
   input  logic          shrink,
   output logic [CW-1:0] level,
   output logic          is_empty,
   output logic          is_full
);
   localparam logic [CW-1:0] TOP = CW'(DEPTH);

   always_ff @(posedge clk) begin
      if (rst)
         level <= '0;
      else if (grow && !shrink)
         level <= level + CW'(1);
      else if (shrink && !grow)
         level <= level - CW'(1);
   end

   assign is_empty = (level == '0);
   assign is_full  = (level == TOP);

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
      level <= TOP);
endmodule

// File: rtl/rvq_fifo.sv
module rvq_fifo #(
   parameter int DEPTH        = 4,
   parameter int WIDTH        = 8,
   parameter bit READY_PASS   = 1'b0,
   parameter bit VALID_BYPASS = 1'b0,
   localparam int PW = rvq_pkg::slot_bits(DEPTH),
   localparam int CW = rvq_pkg::fill_bits(DEPTH)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [WIDTH-1:0] in_data,
   output logic             in_ready,
   output logic             out_valid,
   output logic [WIDTH-1:0] out_data,
   input  logic             out_ready,
   output logic [CW-1:0]    fill
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("rvq_fifo: DEPTH must be at least 1");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("rvq_fifo: WIDTH must be at least 1");
   end

   logic          take, give, empty, full, through;
   logic [PW-1:0] wpos, rpos;
   logic [WIDTH-1:0] held;

   assign take = in_valid && in_ready;
   assign give = out_valid && out_ready;

   if (READY_PASS) begin : g_ready_pass
      assign in_ready = !full || out_ready;
   end else begin : g_ready_reg
      assign in_ready = !full;
   end

   if (VALID_BYPASS) begin : g_valid_bypass
      assign out_valid = !empty || in_valid;
      assign out_data  = empty ? in_data : held;
      assign through   = empty && take && give;
   end else begin : g_valid_reg
      assign out_valid = !empty;
      assign out_data  = held;
      assign through   = 1'b0;
   end

   rvq_occupancy #(.DEPTH(DEPTH)) u_occ (
      .clk(clk), .rst(rst), .grow(take), .shrink(give),
      .level(fill), .is_empty(empty), .is_full(full));

   rvq_wrap_ptr #(.DEPTH(DEPTH)) u_wptr (
      .clk(clk), .rst(rst), .step(take), .pos(wpos));

   rvq_wrap_ptr #(.DEPTH(DEPTH)) u_rptr (
      .clk(clk), .rst(rst), .step(give), .pos(rpos));

   rvq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
      .clk(clk), .wr_en(take && !through), .wr_pos(wpos), .wr_word(in_data),
      .rd_pos(rpos), .rd_word(held));

   assert_fill_step_R2: assert property (@(posedge clk) disable iff (rst)
      (take != give) |=> (int'(fill) == int'($past(fill)) + ($past(take) ? 1 : -1)));

   assert_fill_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (take == give) |=> (fill == $past(fill)));

   assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
      (give && fill == '0) |-> (VALID_BYPASS && take));

   assert_ptr_gap_R6: assert property (@(posedge clk) disable iff (rst)
      int'(wpos) == (int'(rpos) + int'(fill)) % DEPTH);

   assert_full_swap_R7: assert property (@(posedge clk) disable iff (rst)
      (int'(fill) == DEPTH && take) |=> (int'(fill) == DEPTH));

   assert_empty_pass_R8: assert property (@(posedge clk) disable iff (rst)
      (fill == '0 && give) |=> (fill == '0));
endmodule

// File: tb/test_rvq_fifo.sv
module test_rvq_fifo;
   localparam int CLK_PERIOD = 10;
   localparam int DA = 4;
   localparam int DB = 3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic [7:0] in_data = '0;
   logic out_ready = 1'b0;

   logic a_ir, a_ov, b_ir, b_ov;
   logic [7:0] a_od, b_od;
   logic [2:0] a_fill;
   logic [1:0] b_fill;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   string data_tag = "R5";

   logic [7:0] qa[$];
   logic [7:0] qb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   // configuration A: both switches clear
   rvq_fifo #(.DEPTH(DA), .WIDTH(8), .READY_PASS(1'b0), .VALID_BYPASS(1'b0)) i_rvq_fifo (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(a_ir),
      .out_valid(a_ov), .out_data(a_od), .out_ready(out_ready), .fill(a_fill));

   // configuration B: both switches set
   rvq_fifo #(.DEPTH(DB), .WIDTH(8), .READY_PASS(1'b1), .VALID_BYPASS(1'b1)) i_rvq_fifo_b (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(b_ir),
      .out_valid(b_ov), .out_data(b_od), .out_ready(out_ready), .fill(b_fill));

   function automatic bit exp_ready(int n, int d, bit pass, bit r);
      return pass ? ((n < d) || r) : (n < d);
   endfunction

   function automatic bit exp_valid(int n, bit byp, bit v);
      return byp ? ((n > 0) || v) : (n > 0);
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic step(input bit v, input logic [7:0] d, input bit r);
      bit eir, eov, fin_a, fout_a, fin_b, fout_b;
      @(negedge clk);
      in_valid = v; in_data = d; out_ready = r;
      #1;
      // A
      eir = exp_ready(qa.size(), DA, 1'b0, r);
      eov = exp_valid(qa.size(), 1'b0, v);
      check("R3", "A in_ready", a_ir, eir);
      check("R4", "A out_valid", a_ov, eov);
      if (eov) check(data_tag, "A out_data", a_od, qa[0]);
      fin_a = v && eir; fout_a = eov && r;
      // B
      eir = exp_ready(qb.size(), DB, 1'b1, r);
      eov = exp_valid(qb.size(), 1'b1, v);
      check("R7", "B in_ready", b_ir, eir);
      check(qb.size() == 0 ? "R8" : "R9", "B out_valid", b_ov, eov);
      if (eov) check(qb.size() == 0 ? "R8" : data_tag, "B out_data", b_od,
                     qb.size() == 0 ? int'(d) : int'(qb[0]));
      fin_b = v && eir; fout_b = eov && r;
      @(posedge clk);
      #1;
      if (fout_a) void'(qa.pop_front());
      if (fin_a) qa.push_back(d);
      if (fout_b && qb.size() == 0) begin
         // passed straight through
      end else begin
         if (fout_b) void'(qb.pop_front());
         if (fin_b) qb.push_back(d);
      end
      check("R2", "A fill", a_fill, qa.size());
      check("R2", "B fill", b_fill, qb.size());
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      // R1: reset state
      check("R1", "A fill", a_fill, 0);
      check("R1", "A in_ready", a_ir, 1);
      check("R1", "A out_valid", a_ov, 0);
      check("R1", "B fill", b_fill, 0);
      check("R1", "B out_valid", b_ov, 0);

      // R8: bypass from empty, consumer ready
      step(1'b1, 8'hA5, 1'b1);
      step(1'b1, 8'h3C, 1'b1);
      // R3/R7: fill to full with consumer stalled, then push on full
      for (int i = 0; i < DA + 2; i++) step(1'b1, 8'(8'h10 + i), 1'b0);
      check("R3", "A full fill", a_fill, DA);
      check("R7", "B full fill", b_fill, DB);
      // R7: push while popping on a full queue
      step(1'b1, 8'h77, 1'b1);
      check("R7", "B stays full", b_fill, DB);
      // R4/R5: drain completely, then idle-ready on empty
      for (int i = 0; i < DA + 2; i++) step(1'b0, 8'h00, 1'b1);
      check("R4", "A empty fill", a_fill, 0);
      step(1'b0, 8'hEE, 1'b1);

      // R6: long streams crossing the wrap point many times
      data_tag = "R6";
      for (int i = 0; i < 200; i++) step(1'b1, 8'(i * 7 + 1), (i % 3) != 0);
      for (int i = 0; i < 8; i++) step(1'b0, 8'h00, 1'b1);
      data_tag = "R5";

      // random traffic with shifting bias
      for (int seg = 0; seg < 6; seg++) begin
         for (int i = 0; i < 500; i++) begin
            bit v, r;
            v = ($urandom % 4) < ((seg % 3) + 1);
            r = ($urandom % 4) < (3 - (seg % 3));
            step(v, 8'($urandom), r);
         end
      end
      for (int i = 0; i < 8; i++) step(1'b0, 8'h00, 1'b1);
      check("R5", "A drained", a_fill, 0);
      check("R5", "B drained", b_fill, 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule